// File: doc/BRIEF.md
# Cache line invalidation controller

This block runs privileged invalidate commands against the tag stores of a split instruction cache and data cache. A command names a subset of the two caches and one of three scopes. The scope is a single line that matches a physical address, every line whose physical address lies in a given 4 KiB page, or every entry. The block clears valid state by walking the tag arrays. It ends each accepted command with either a one-cycle done pulse or, if the requester was not in supervisor state, a one-cycle trap pulse that leaves every array untouched.

Each cache is modelled inside the block as a 4-way, 64-set array of 16-byte lines that holds physical tags with a valid bit and a dirty bit per entry. Invalidation discards dirty state. There is no write-back path. A fill port installs tags. A combinational lookup port reports hits, so that an environment can check the cache contents after each command. Addresses on all three ports are line addresses, meaning the physical byte address with its four offset bits removed.

Top module: `cache_inval_ctrl`

## Requirements
- R1: After reset every entry of both caches is invalid, `cmd_ready` is high, and `done` and `trap` are low.
- R2: A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the cycle after acceptance until the cycle in which `done` is high, and it is high in that cycle.
- R3: If `cmd_super` is low when a command is taken, `trap` is high in the next cycle, `done` stays low, and no entry changes.
- R4: If `cmd_caches` is 2'b00 in a supervisor command, `done` is high in the next cycle and no entry changes.
- R5: Line scope (`cmd_scope` = 2'b00) invalidates, in each selected cache, the entry in set `cmd_line[5:0]` whose tag equals `cmd_line[27:6]`. If no entry matches, the command completes normally. `done` is high two cycles after acceptance.
- R6: Page scope (`cmd_scope` = 2'b01) invalidates every entry in each selected cache whose physical page (byte address bits [31:12], which is `cmd_line[27:8]`) equals that of the command. Entries in other pages survive. `done` is high 65 cycles after acceptance.
- R7: All scope (`cmd_scope` = 2'b10, and 2'b11 likewise) invalidates every entry in each selected cache. It clears one set per cycle, and `done` is high 65 cycles after acceptance.
- R8: `cmd_caches[0]` selects the instruction cache and `cmd_caches[1]` selects the data cache. A cache that is not selected is left unchanged. On the fill and lookup ports, `fill_sel`/`look_sel` = 0 means the instruction cache and 1 means the data cache.
- R9: `look_hit` is high when a valid entry of the chosen cache matches `look_line`. `look_dirty` is high when that entry was filled with `fill_dirty` = 1. An invalidated entry reports neither.
- R10: Under all scope, a fill that writes the set being cleared in the same cycle ends invalid. A fill to a set the sweep has already passed stays valid. A fill to a set the sweep has not reached is cleared.
- R11: `done` and `trap` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_scope | input | 2 | 00 line, 01 page, 10/11 all |
| cmd_caches | input | 2 | Bit 0 instruction cache, bit 1 data cache |
| cmd_super | input | 1 | Requester is in supervisor state |
| cmd_line | input | 28 | Physical line address of the command |
| done | output | 1 | Command completed (pulse) |
| trap | output | 1 | Privilege violation (pulse) |
| fill_valid | input | 1 | Install a tag this cycle |
| fill_sel | input | 1 | Fill target: 0 instruction, 1 data |
| fill_way | input | 2 | Way to write |
| fill_line | input | 28 | Physical line address to install |
| fill_dirty | input | 1 | Dirty state of the installed entry |
| look_sel | input | 1 | Lookup target: 0 instruction, 1 data |
| look_line | input | 28 | Physical line address to look up |
| look_hit | output | 1 | Lookup hit |
| look_dirty | output | 1 | Lookup hit on a dirty entry |

## Verification
A fill and the set clear of an all-scope sweep can land in the same cycle. The bench provokes this by starting a sweep and then driving fills timed by counting cycles from acceptance. One fill hits the set that is being cleared in that cycle, one hits a set the sweep has already passed, and one hits a set the sweep has not reached. After done, the lookup must miss on the first and third fills and hit on the second. This shows that invalidation overrides the fill only where the two coincide or where the sweep arrives later.

// File: rtl/cinv_pkg.sv
// Shared encodings for the cache invalidation controller.
// Assumes a two-bit scope field and a two-cache split organisation.
package cinv_pkg;

    localparam logic [1:0] SCOPE_LINE = 2'b00;
    localparam logic [1:0] SCOPE_PAGE = 2'b01;

    typedef enum logic [1:0] {
        CLR_LINE = 2'b00,
        CLR_PAGE = 2'b01,
        CLR_ALL  = 2'b10
    } clr_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LINE  = 2'b01,
        ST_SWEEP = 2'b10
    } seq_state_e;

    // Map the command scope field onto a clear kind.
    function automatic clr_kind_e scope_to_kind(input logic [1:0] scope);
        case (scope)
            SCOPE_LINE: return CLR_LINE;
            SCOPE_PAGE: return CLR_PAGE;
            default:    return CLR_ALL;
        endcase
    endfunction

endpackage

// File: rtl/cinv_tag_bank.sv
// Tag, valid and dirty storage for one set-associative cache.
// It also computes the per-way clear mask for the set being invalidated.
// Assumes WAYS >= 2 and PAGE_SHIFT < TAG_W. When a fill and a clear
// hit the same entry in one cycle, the clear wins.
module cinv_tag_bank
    import cinv_pkg::*;
#(
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    parameter int TAG_W      = 22,
    parameter int PAGE_SHIFT = 2,
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              fill_dirty,
    input  logic              clr_en,
    input  clr_kind_e         clr_kind,
    input  logic [SET_W-1:0]  clr_set,
    input  logic [TAG_W-1:0]  clr_tag,
    input  logic [SET_W-1:0]  look_set,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic              look_dirty
);

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  vld_q   [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];

    logic [WAYS-1:0]  line_hit;
    logic [WAYS-1:0]  page_hit;
    logic [WAYS-1:0]  probe_hit;
    logic [WAYS-1:0]  clr_mask;

    // Per-way comparators for the clear set and the lookup set.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign line_hit[w]  = vld_q[clr_set][w] &&
                              (tag_q[clr_set][w] == clr_tag);
        assign page_hit[w]  = vld_q[clr_set][w] &&
                              (tag_q[clr_set][w][TAG_W-1:PAGE_SHIFT] ==
                               clr_tag[TAG_W-1:PAGE_SHIFT]);
        assign probe_hit[w] = vld_q[look_set][w] &&
                              (tag_q[look_set][w] == look_tag);
    end

    // Select which ways of the current set are cleared.
    always_comb begin
        case (clr_kind)
            CLR_LINE: clr_mask = line_hit;
            CLR_PAGE: clr_mask = page_hit;
            default:  clr_mask = '1;
        endcase
    end

    assign look_hit   = |probe_hit;
    assign look_dirty = |(probe_hit & dirty_q[look_set]);

    // Valid and dirty state: reset clears, fill sets, clear overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]   <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            if (fill_en) begin
                vld_q[fill_set][fill_way]   <= 1'b1;
                dirty_q[fill_set][fill_way] <= fill_dirty;
            end
            if (clr_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (clr_mask[w]) begin
                        vld_q[clr_set][w]   <= 1'b0;
                        dirty_q[clr_set][w] <= 1'b0;
                    end
                end
            end
        end
    end

    // Tag storage, written by fills only and not reset.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_set][fill_way] <= fill_tag;
        end
    end

endmodule

// File: rtl/cinv_seq.sv
// Command sequencer: accepts one command at a time, checks privilege,
// and steps through one set (line scope) or all sets (page/all scope).
// It drives the clear request for both banks. Assumes SETS is a power of two.
module cinv_seq
    import cinv_pkg::*;
#(
    parameter int SETS     = 64,
    parameter int LINE_W   = 28,
    localparam int SET_W   = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_scope,
    input  logic [1:0]        cmd_caches,
    input  logic              cmd_super,
    input  logic [LINE_W-1:0] cmd_line,
    output logic [1:0]        clr_en,
    output clr_kind_e         clr_kind,
    output logic [SET_W-1:0]  clr_set,
    output logic [LINE_W-1:0] line_q,
    output logic              done,
    output logic              trap
);

    localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);

    seq_state_e       st_q;
    logic [SET_W-1:0] idx_q;
    logic [1:0]       sel_q;
    clr_kind_e        kind_q;

    assign cmd_ready = (st_q == ST_IDLE);
    assign clr_en    = (st_q != ST_IDLE) ? sel_q : 2'b00;
    assign clr_kind  = kind_q;
    assign clr_set   = (st_q == ST_SWEEP) ? idx_q : line_q[SET_W-1:0];

    // Command state machine with registered done and trap pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            sel_q  <= 2'b00;
            kind_q <= CLR_ALL;
            line_q <= '0;
            done   <= 1'b0;
            trap   <= 1'b0;
        end else begin
            done <= 1'b0;
            trap <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        line_q <= cmd_line;
                        sel_q  <= cmd_caches;
                        kind_q <= scope_to_kind(cmd_scope);
                        idx_q  <= '0;
                        if (!cmd_super) begin
                            trap <= 1'b1;
                        end else if (cmd_caches == 2'b00) begin
                            done <= 1'b1;
                        end else if (cmd_scope == SCOPE_LINE) begin
                            st_q <= ST_LINE;
                        end else begin
                            st_q <= ST_SWEEP;
                        end
                    end
                end
                ST_LINE: begin
                    st_q <= ST_IDLE;
                    done <= 1'b1;
                end
                ST_SWEEP: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_SET) begin
                        st_q <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cache_inval_ctrl.sv
// Top level of the cache invalidation controller. It joins the sequencer
// to one tag bank per cache and routes the fill and lookup ports.
// Bank 0 is the instruction cache and bank 1 is the data cache. Addresses
// are physical line addresses (byte address without the line offset).
module cache_inval_ctrl
    import cinv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int PAGE_BYTES = 4096,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int SET_W      = $clog2(SETS),
    localparam int WAY_W      = $clog2(WAYS),
    localparam int LINE_W     = ADDR_W - OFF_W,
    localparam int TAG_W      = LINE_W - SET_W,
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES) - OFF_W - SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_scope,
    input  logic [1:0]        cmd_caches,
    input  logic              cmd_super,
    input  logic [LINE_W-1:0] cmd_line,
    output logic              done,
    output logic              trap,
    input  logic              fill_valid,
    input  logic              fill_sel,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_dirty,
    input  logic              look_sel,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    output logic              look_dirty
);

    logic [1:0]        clr_en;
    clr_kind_e         clr_kind;
    logic [SET_W-1:0]  clr_set;
    logic [LINE_W-1:0] line_q;
    logic [1:0]        bank_hit;
    logic [1:0]        bank_dirty;

    cinv_seq #(
        .SETS   (SETS),
        .LINE_W (LINE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_scope  (cmd_scope),
        .cmd_caches (cmd_caches),
        .cmd_super  (cmd_super),
        .cmd_line   (cmd_line),
        .clr_en     (clr_en),
        .clr_kind   (clr_kind),
        .clr_set    (clr_set),
        .line_q     (line_q),
        .done       (done),
        .trap       (trap)
    );

    // One bank per cache; index 0 instruction, index 1 data.
    for (genvar c = 0; c < 2; c++) begin : g_cache
        cinv_tag_bank #(
            .SETS       (SETS),
            .WAYS       (WAYS),
            .TAG_W      (TAG_W),
            .PAGE_SHIFT (PAGE_SHIFT)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .fill_en    (fill_valid && (fill_sel == 1'(c))),
            .fill_set   (fill_line[SET_W-1:0]),
            .fill_way   (fill_way),
            .fill_tag   (fill_line[LINE_W-1:SET_W]),
            .fill_dirty (fill_dirty),
            .clr_en     (clr_en[c]),
            .clr_kind   (clr_kind),
            .clr_set    (clr_set),
            .clr_tag    (line_q[LINE_W-1:SET_W]),
            .look_set   (look_line[SET_W-1:0]),
            .look_tag   (look_line[LINE_W-1:SET_W]),
            .look_hit   (bank_hit[c]),
            .look_dirty (bank_dirty[c])
        );
    end

    assign look_hit   = bank_hit[look_sel];
    assign look_dirty = bank_dirty[look_sel];

endmodule

// File: rtl/cinv_ctrl_chk.sv
// Protocol checker for the cache invalidation controller, bound to the top.
// It watches only the command and completion ports.
module cinv_ctrl_chk #(
    parameter int SETS = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_scope,
    input logic [1:0] cmd_caches,
    input logic       cmd_super,
    input logic       done,
    input logic       trap
);

    localparam int CNT_W = $clog2(SETS + 2) + 1;

    logic             take;
    logic             sweep_pend;
    logic [CNT_W-1:0] sweep_cnt;

    assign take = cmd_valid && cmd_ready;

    // Count cycles from acceptance of a sweep command to its done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_pend <= 1'b0;
            sweep_cnt  <= '0;
        end else if (take && cmd_super && (cmd_caches != 2'b00) &&
                     (cmd_scope != 2'b00)) begin
            sweep_pend <= 1'b1;
            sweep_cnt  <= CNT_W'(1);
        end else if (sweep_pend) begin
            sweep_cnt <= sweep_cnt + 1'b1;
            if (done) sweep_pend <= 1'b0;
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_super && (cmd_caches != 2'b00) |=> !cmd_ready); // R2
    AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready); // R2
    AST_USER_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        take && !cmd_super |=> trap && !done); // R3
    AST_EMPTY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_super && (cmd_caches == 2'b00) |=> done); // R4
    AST_LINE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_super && (cmd_caches != 2'b00) && (cmd_scope == 2'b00)
        |=> !done ##1 done); // R5
    AST_SWEEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done && sweep_pend |-> sweep_cnt == CNT_W'(SETS + 1)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && trap)); // R11

endmodule

bind cache_inval_ctrl cinv_ctrl_chk #(.SETS(SETS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_scope  (cmd_scope),
    .cmd_caches (cmd_caches),
    .cmd_super  (cmd_super),
    .done       (done),
    .trap       (trap)
);

// File: tb/cache_inval_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for cache_inval_ctrl: one task per scenario.
module cache_inval_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_scope = 2'b00;
    logic [1:0]  cmd_caches = 2'b00;
    logic        cmd_super = 1'b0;
    logic [27:0] cmd_line = '0;
    logic        done;
    logic        trap;
    logic        fill_valid = 1'b0;
    logic        fill_sel = 1'b0;
    logic [1:0]  fill_way = 2'b00;
    logic [27:0] fill_line = '0;
    logic        fill_dirty = 1'b0;
    logic        look_sel = 1'b0;
    logic [27:0] look_line = '0;
    logic        look_hit;
    logic        look_dirty;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cache_inval_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_scope(cmd_scope), .cmd_caches(cmd_caches), .cmd_super(cmd_super),
        .cmd_line(cmd_line), .done(done), .trap(trap),
        .fill_valid(fill_valid), .fill_sel(fill_sel), .fill_way(fill_way),
        .fill_line(fill_line), .fill_dirty(fill_dirty),
        .look_sel(look_sel), .look_line(look_line),
        .look_hit(look_hit), .look_dirty(look_dirty)
    );

    function automatic logic [27:0] la(input logic [31:0] byte_addr);
        return byte_addr[31:4];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fill(input bit sel, input logic [1:0] way, input logic [31:0] a, input bit dirty);
        fill_valid = 1'b1; fill_sel = sel; fill_way = way;
        fill_line = la(a); fill_dirty = dirty;
        @(posedge clk); @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic probe(input bit sel, input logic [31:0] a, input bit exp_hit,
                         input bit exp_dirty, input string req);
        look_sel = sel; look_line = la(a);
        #0.5;
        chk(req, {look_hit, look_dirty}, {exp_hit, exp_dirty});
    endtask

    // Drive one command; returns at the falling edge after acceptance (cycle 1).
    task automatic issue(input logic [1:0] scope, input logic [1:0] caches,
                         input logic [31:0] a, input bit sup);
        cmd_valid = 1'b1; cmd_scope = scope; cmd_caches = caches;
        cmd_line = la(a); cmd_super = sup;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Called at cycle 1 (from issue); checks done appears exactly at cycle n.
    task automatic expect_done(input int n, input string req);
        bit early = 0;
        for (int c = 1; c < n; c++) begin
            if (done !== 1'b0 || cmd_ready !== 1'b0 || trap !== 1'b0) early = 1;
            @(negedge clk);
        end
        chk({req, " no early completion"}, early, 0);
        chk({req, " done/ready/trap at completion"}, {done, cmd_ready, trap}, 3'b110);
        @(negedge clk);
        chk({req, " done pulse ends"}, done, 0);
    endtask

    task automatic t_reset();
        chk("R1 ready/done/trap after reset", {cmd_ready, done, trap}, 3'b100);
        fill(1'b0, 2'd0, 32'h0000_1230, 1'b0);
        fill(1'b1, 2'd3, 32'hABCD_EF00, 1'b1);
        probe(1'b1, 32'hABCD_EF00, 1'b1, 1'b1, "R9 filled entry hits dirty");
        do_reset();
        probe(1'b0, 32'h0000_1230, 1'b0, 1'b0, "R1 instruction entry cleared by reset");
        probe(1'b1, 32'hABCD_EF00, 1'b0, 1'b0, "R1 data entry cleared by reset");
    endtask

    task automatic t_trap();
        fill(1'b0, 2'd1, 32'h0000_4440, 1'b0);
        fill(1'b1, 2'd1, 32'h0000_4440, 1'b1);
        issue(2'b10, 2'b11, 32'h0, 1'b0);
        chk("R3 trap in cycle after user command", {trap, done}, 2'b10);
        chk("R2 ready stays high after trap", cmd_ready, 1);
        @(negedge clk);
        chk("R11 trap is one cycle", {trap, done}, 2'b00);
        probe(1'b0, 32'h0000_4440, 1'b1, 1'b0, "R3 instruction entry kept");
        probe(1'b1, 32'h0000_4440, 1'b1, 1'b1, "R3 data entry kept");
    endtask

    task automatic t_neither();
        issue(2'b10, 2'b00, 32'h0, 1'b1);
        chk("R4 done in cycle after empty select", {done, trap, cmd_ready}, 3'b101);
        @(negedge clk);
        chk("R11 done is one cycle", done, 0);
        probe(1'b0, 32'h0000_4440, 1'b1, 1'b0, "R4 instruction entry kept");
        probe(1'b1, 32'h0000_4440, 1'b1, 1'b1, "R4 data entry kept");
    endtask

    task automatic t_line();
        do_reset();
        fill(1'b0, 2'd0, 32'h0055_0A70, 1'b0);
        fill(1'b1, 2'd2, 32'h0055_0A70, 1'b1);
        fill(1'b1, 2'd0, 32'h0066_0A70, 1'b0);
        issue(2'b00, 2'b10, 32'h0055_0A70, 1'b1);
        expect_done(2, "R5 line timing");
        probe(1'b1, 32'h0055_0A70, 1'b0, 1'b0, "R5 matching data line cleared");
        probe(1'b1, 32'h0066_0A70, 1'b1, 1'b0, "R5 other tag in same set kept");
        probe(1'b0, 32'h0055_0A70, 1'b1, 1'b0, "R8 unselected instruction cache kept");
        issue(2'b00, 2'b11, 32'h0777_0A70, 1'b1);
        expect_done(2, "R5 line miss timing");
        probe(1'b1, 32'h0066_0A70, 1'b1, 1'b0, "R5 miss changes nothing");
        issue(2'b00, 2'b01, 32'h0055_0A70, 1'b1);
        expect_done(2, "R8 instruction-only line");
        probe(1'b0, 32'h0055_0A70, 1'b0, 1'b0, "R8 instruction line cleared");
    endtask

    task automatic t_page();
        do_reset();
        fill(1'b1, 2'd0, 32'h1234_5000, 1'b1);
        fill(1'b1, 2'd0, 32'h1234_53F0, 1'b0);
        fill(1'b1, 2'd0, 32'h1234_5C40, 1'b1);
        fill(1'b1, 2'd1, 32'h1234_6000, 1'b0);
        fill(1'b1, 2'd1, 32'h1234_4FF0, 1'b1);
        fill(1'b0, 2'd0, 32'h1234_5400, 1'b0);
        fill(1'b0, 2'd1, 32'h1234_7400, 1'b0);
        issue(2'b01, 2'b11, 32'h1234_5000, 1'b1);
        expect_done(65, "R6 page timing");
        probe(1'b1, 32'h1234_5000, 1'b0, 1'b0, "R6 page line set 0 cleared");
        probe(1'b1, 32'h1234_53F0, 1'b0, 1'b0, "R6 page line set 63 cleared");
        probe(1'b1, 32'h1234_5C40, 1'b0, 1'b0, "R6 page line set 4 cleared");
        probe(1'b0, 32'h1234_5400, 1'b0, 1'b0, "R6 instruction page line cleared");
        probe(1'b1, 32'h1234_6000, 1'b1, 1'b0, "R6 next page kept");
        probe(1'b1, 32'h1234_4FF0, 1'b1, 1'b1, "R6 previous page kept");
        probe(1'b0, 32'h1234_7400, 1'b1, 1'b0, "R6 other instruction page kept");
    endtask

    task automatic t_all();
        do_reset();
        fill(1'b0, 2'd0, 32'h0100_0000, 1'b0);
        fill(1'b0, 2'd3, 32'hFFFF_FFF0, 1'b0);
        fill(1'b1, 2'd1, 32'h0100_0000, 1'b1);
        fill(1'b1, 2'd2, 32'h8000_0200, 1'b0);
        issue(2'b10, 2'b01, 32'h0, 1'b1);
        expect_done(65, "R7 all timing");
        probe(1'b0, 32'h0100_0000, 1'b0, 1'b0, "R7 instruction set 0 cleared");
        probe(1'b0, 32'hFFFF_FFF0, 1'b0, 1'b0, "R7 instruction set 63 cleared");
        probe(1'b1, 32'h0100_0000, 1'b1, 1'b1, "R8 data cache untouched by instruction all");
        issue(2'b11, 2'b10, 32'h0, 1'b1);
        expect_done(65, "R7 scope 11 timing");
        probe(1'b1, 32'h0100_0000, 1'b0, 1'b0, "R9 dirty data discarded by scope 11");
        probe(1'b1, 32'h8000_0200, 1'b0, 1'b0, "R7 scope 11 clears data cache");
    endtask

    task automatic t_dirty();
        do_reset();
        fill(1'b1, 2'd3, 32'h0BAD_0C00, 1'b1);
        fill(1'b1, 2'd2, 32'h0C0F_0C00, 1'b0);
        probe(1'b1, 32'h0BAD_0C00, 1'b1, 1'b1, "R9 dirty entry reported");
        probe(1'b1, 32'h0C0F_0C00, 1'b1, 1'b0, "R9 clean entry reported");
        probe(1'b0, 32'h0BAD_0C00, 1'b0, 1'b0, "R9 other cache misses");
        issue(2'b00, 2'b10, 32'h0BAD_0C00, 1'b1);
        expect_done(2, "R9 line on dirty entry");
        probe(1'b1, 32'h0BAD_0C00, 1'b0, 1'b0, "R9 dirty entry dropped");
    endtask

    // A fill and the sweep clear meet in one cycle.
    task automatic t_collide();
        do_reset();
        issue(2'b10, 2'b01, 32'h0, 1'b1);
        repeat (10) @(negedge clk);           // cycle 11: sweep clears set 10
        fill_valid = 1'b1; fill_sel = 1'b0; fill_way = 2'd0; fill_dirty = 1'b0;
        fill_line = la(32'h0042_00A0);        // set 10
        @(negedge clk);                        // cycle 12: sweep clears set 11
        fill_line = la(32'h0042_0050);        // set 5, already swept
        @(negedge clk);                        // cycle 13
        fill_line = la(32'h0042_0280);        // set 40, not yet swept
        @(negedge clk);                        // cycle 14
        fill_valid = 1'b0;
        repeat (51) @(negedge clk);           // cycle 65
        chk("R10 sweep completes at cycle 65", {done, cmd_ready}, 2'b11);
        probe(1'b0, 32'h0042_00A0, 1'b0, 1'b0, "R10 coinciding fill cleared");
        probe(1'b0, 32'h0042_0050, 1'b1, 1'b0, "R10 fill behind sweep kept");
        probe(1'b0, 32'h0042_0280, 1'b0, 1'b0, "R10 fill ahead of sweep cleared");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_trap();
        t_neither();
        t_line();
        t_page();
        t_all();
        t_dirty();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule